// File: doc/BRIEF.md
# Receive Path-Overhead Interrupt Status Collector

This block gathers the results of a receive path-overhead processor into two byte-wide interrupt status registers. Single-cycle event pulses (B3 byte error, the five pointer events, acceptance of a new RDI-P code) each latch their own status bit. Four defect levels (LOP-P, AIS-P, C2 unstable, RDI-P unstable) are compared every cycle against their value one cycle earlier. Any change in either direction latches a change bit. The block does not interpret pointers, compute B3 parity or detect defects. It only records what the upstream processor reports.

Software reaches the block through a small synchronous register port. Each status byte is cleared by reading it. An event that arrives in the same cycle as the read is kept. Two mask bytes choose which status bits drive the single interrupt line. A level byte shows the present defect states, and a further register shows the last accepted RDI-P code. The status bits record events whether or not they are masked. The masks act only on the interrupt line.

Top module: `poh_irq_status`

## Requirements
- R1: After synchronous reset, every status bit, every mask bit and the stored RDI-P code read 0, and `irq_out` is low.
- R2: Status byte 0 (address 0) holds, from bit 7 to bit 0: B3 error, new pointer, unknown pointer, pointer decrement, pointer increment, NDF pointer, LOP-P change, AIS-P change.
- R3: An event pulse sampled on a clock edge sets its status bit after that edge. The bit stays set until its byte is read.
- R4: A change of a defect level between two consecutive clock edges sets its change bit. This applies to declaration and to clearing. A level that holds steady sets nothing.
- R5: A read returns the latched byte on `reg_rdata` in the cycle that `reg_rd` is high, and it clears that byte at the clock edge.
- R6: An event or level change sampled on the same edge as the read-clear of its byte is set after that edge. The read data in that cycle does not include it.
- R7: Address 4 returns the present defect levels combinationally: bit 0 AIS-P, bit 1 LOP-P, bit 2 C2 unstable, bit 3 RDI-P unstable, and all other bits 0.
- R8: Status byte 1 (address 1) holds bit 0 new RDI-P value, bit 1 RDI-P unstable change and bit 2 C2 unstable change, with bits 7:3 at 0. The code on `rdi_code_in` is stored when `rdi_new_evt` is high and reads back at address 5 in bits 6:4.
- R9: `irq_out` is high exactly when some status bit and its mask bit are both 1. Mask bytes sit at addresses 2 (for byte 0) and 3 (for byte 1).
- R10: Mask bytes are written by `reg_wr` and read back unchanged. Writes to addresses 0, 1, 4 and 5 have no effect.
- R11: Reading one status byte leaves the other status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b3_err_evt | input | 1 | B3 byte error pulse |
| ptr_new_evt | input | 1 | New pointer pulse |
| ptr_unknown_evt | input | 1 | Unknown pointer pulse |
| ptr_dec_evt | input | 1 | Pointer decrement pulse |
| ptr_inc_evt | input | 1 | Pointer increment pulse |
| ptr_ndf_evt | input | 1 | NDF pointer pulse |
| rdi_new_evt | input | 1 | New validated RDI-P code pulse |
| rdi_code_in | input | 3 | RDI-P code accepted with `rdi_new_evt` |
| lop_lvl | input | 1 | LOP-P defect level |
| ais_lvl | input | 1 | AIS-P defect level |
| c2_unstable_lvl | input | 1 | C2 unstable defect level |
| rdi_unstable_lvl | input | 1 | RDI-P unstable defect level |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe (clears a status byte) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The bench aims at a read that coincides with a new event. A design that clears and then ignores the set would lose that event for good. The bench also lowers a defect after raising it. A rising-edge-only detector would miss the clearing, and a plain level copy would keep setting the change bit while the defect holds. The bench sets status bits while the masks are zero, then opens the mask. A design that gates the latch with the mask would miss the stored event, and one that leaves the mask out of the interrupt would raise `irq_out` early. Reads of one byte while the other holds bits, and writes aimed at status addresses, expose a shared clear or a writable status.

// File: rtl/poh_irq_pkg.sv
package poh_irq_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_STAT  = 2;
    localparam int NUM_DEF   = 4;
    localparam int RDI_W     = 3;
    localparam int RDI_LSB   = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT0 = 3'd0,
        ADR_STAT1 = 3'd1,
        ADR_MASK0 = 3'd2,
        ADR_MASK1 = 3'd3,
        ADR_LEVEL = 3'd4,
        ADR_RDI   = 3'd5,
        ADR_NONE6 = 3'd6,
        ADR_NONE7 = 3'd7
    } reg_addr_e;

    // byte 0 field order is fixed: bit 7 first
    typedef struct packed {
        logic b3_err;
        logic ptr_new;
        logic ptr_unknown;
        logic ptr_dec;
        logic ptr_inc;
        logic ptr_ndf;
        logic lop_chg;
        logic ais_chg;
    } stat0_t;

    typedef struct packed {
        logic [4:0] spare;
        logic       c2_chg;
        logic       rdi_unst_chg;
        logic       rdi_new;
    } stat1_t;

    // index order of the defect vector: 0 AIS, 1 LOP, 2 C2, 3 RDI unstable
    typedef struct packed {
        logic rdi_unst;
        logic c2_unst;
        logic lop;
        logic ais;
    } defect_t;

    function automatic logic [BYTE_W-1:0] level_byte(defect_t d);
        return {{(BYTE_W-NUM_DEF){1'b0}}, d};
    endfunction

    function automatic logic [BYTE_W-1:0] rdi_byte(logic [RDI_W-1:0] code);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[RDI_LSB +: RDI_W] = code;
        return b;
    endfunction

endpackage

// File: rtl/poh_level_change.sv
module poh_level_change #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // follows the level through reset, so a level present at
        // reset release is not reported as a change
        always_ff @(posedge clk) begin
            prev_q[i] <= lvl[i];
        end
        assign chg[i] = lvl[i] ^ prev_q[i];
    end
endmodule

// File: rtl/poh_stat_reg.sv
module poh_stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         irq_any
);
    logic [W-1:0] stat_q, mask_q, stat_keep;

    assign stat_keep = rd_clr ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_keep | set;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign stat    = stat_q;
    assign mask    = mask_q;
    assign irq_any = |(stat_q & mask_q);

    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && set == '0) |=> (stat == '0));

    assert_event_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((stat & $past(set)) == $past(set)));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/poh_reg_port.sv
module poh_reg_port
    import poh_irq_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [BYTE_W-1:0]   stat0,
    input  logic [BYTE_W-1:0]   stat1,
    input  logic [BYTE_W-1:0]   mask0,
    input  logic [BYTE_W-1:0]   mask1,
    input  defect_t             levels,
    input  logic [RDI_W-1:0]    rdi_code,
    output logic [NUM_STAT-1:0] rd_clr,
    output logic [NUM_STAT-1:0] mask_we,
    output logic [BYTE_W-1:0]   rdata
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    always_comb begin
        rd_clr  = '0;
        mask_we = '0;
        rdata   = '0;
        unique case (a)
            ADR_STAT0: begin rdata = stat0; rd_clr[0] = rd; end
            ADR_STAT1: begin rdata = stat1; rd_clr[1] = rd; end
            ADR_MASK0: begin rdata = mask0; mask_we[0] = wr; end
            ADR_MASK1: begin rdata = mask1; mask_we[1] = wr; end
            ADR_LEVEL: rdata = level_byte(levels);
            ADR_RDI:   rdata = rdi_byte(rdi_code);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/poh_irq_status.sv
module poh_irq_status
    import poh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              b3_err_evt,
    input  logic              ptr_new_evt,
    input  logic              ptr_unknown_evt,
    input  logic              ptr_dec_evt,
    input  logic              ptr_inc_evt,
    input  logic              ptr_ndf_evt,
    input  logic              rdi_new_evt,
    input  logic [2:0]        rdi_code_in,
    input  logic              lop_lvl,
    input  logic              ais_lvl,
    input  logic              c2_unstable_lvl,
    input  logic              rdi_unstable_lvl,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_out
);
    defect_t             lvl;
    logic [NUM_DEF-1:0]  chg;
    stat0_t              set0;
    stat1_t              set1;
    logic [NUM_STAT-1:0][BYTE_W-1:0] set_v, stat_v, mask_v;
    logic [NUM_STAT-1:0] rd_clr, mask_we, irq_v;
    logic [RDI_W-1:0]    rdi_q;

    assign lvl = '{rdi_unst: rdi_unstable_lvl, c2_unst: c2_unstable_lvl,
                   lop: lop_lvl, ais: ais_lvl};

    poh_level_change #(.N(NUM_DEF)) u_chg (
        .clk (clk),
        .lvl (lvl),
        .chg (chg)
    );

    always_comb begin
        set0 = '{b3_err: b3_err_evt, ptr_new: ptr_new_evt,
                 ptr_unknown: ptr_unknown_evt, ptr_dec: ptr_dec_evt,
                 ptr_inc: ptr_inc_evt, ptr_ndf: ptr_ndf_evt,
                 lop_chg: chg[1], ais_chg: chg[0]};
        set1 = '{spare: '0, c2_chg: chg[2], rdi_unst_chg: chg[3],
                 rdi_new: rdi_new_evt};
    end

    assign set_v[0] = set0;
    assign set_v[1] = set1;

    for (genvar b = 0; b < NUM_STAT; b++) begin : g_stat
        poh_stat_reg #(.W(BYTE_W)) u_stat (
            .clk        (clk),
            .rst        (rst),
            .set        (set_v[b]),
            .rd_clr     (rd_clr[b]),
            .mask_we    (mask_we[b]),
            .mask_wdata (reg_wdata),
            .stat       (stat_v[b]),
            .mask       (mask_v[b]),
            .irq_any    (irq_v[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)              rdi_q <= '0;
        else if (rdi_new_evt) rdi_q <= rdi_code_in;
    end

    poh_reg_port u_port (
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .stat0    (stat_v[0]),
        .stat1    (stat_v[1]),
        .mask0    (mask_v[0]),
        .mask1    (mask_v[1]),
        .levels   (lvl),
        .rdi_code (rdi_q),
        .rd_clr   (rd_clr),
        .mask_we  (mask_we),
        .rdata    (reg_rdata)
    );

    assign irq_out = |irq_v;

    assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
        (((stat_v[0] & mask_v[0]) | (stat_v[1] & mask_v[1])) != '0) |-> irq_out);

    assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
        (((stat_v[0] & mask_v[0]) | (stat_v[1] & mask_v[1])) == '0) |-> !irq_out);

    assert_lop_change_R4: assert property (@(posedge clk) disable iff (rst)
        (lop_lvl != $past(lop_lvl)) |=> stat_v[0][1]);

    assert_spare_zero_R8: assert property (@(posedge clk) disable iff (rst)
        stat_v[1][7:3] == '0);
endmodule

// File: tb/tb_poh_irq_status.sv
module tb_poh_irq_status;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b3, pnew, punk, pdec, pinc, pndf, rnew;
    logic [2:0] rcode;
    logic lop, ais, c2, runst;
    logic [2:0] addr;
    logic rd, wr;
    logic [7:0] wdata, rdata;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [7:0] m_s0, m_s1, m_k0, m_k1;
    logic [2:0] m_rdi;
    logic [3:0] m_prev;

    always #2.5 clk = ~clk;

    poh_irq_status dut (
        .clk(clk), .rst(rst),
        .b3_err_evt(b3), .ptr_new_evt(pnew), .ptr_unknown_evt(punk),
        .ptr_dec_evt(pdec), .ptr_inc_evt(pinc), .ptr_ndf_evt(pndf),
        .rdi_new_evt(rnew), .rdi_code_in(rcode),
        .lop_lvl(lop), .ais_lvl(ais), .c2_unstable_lvl(c2),
        .rdi_unstable_lvl(runst),
        .reg_addr(addr), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_out(irq)
    );

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_s0;
            3'd1: return m_s1;
            3'd2: return m_k0;
            3'd3: return m_k1;
            3'd4: return {4'b0, runst, c2, lop, ais};
            3'd5: return {1'b0, m_rdi, 4'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R8";
            3'd2, 3'd3: return "R10";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        b3 = 0; pnew = 0; punk = 0; pdec = 0; pinc = 0; pndf = 0; rnew = 0;
        rd = 0; wr = 0; wdata = 8'h00; addr = 3'd0;
    endtask

    // inputs are already driven after a falling edge
    task automatic tick(input string tag);
        logic [7:0] n0, n1;
        logic [3:0] cur;
        #1;
        if (rd) check(rdata, exp_rd(addr), (tag != "") ? tag : addr_tag(addr));
        check({7'b0, irq}, {7'b0, |((m_s0 & m_k0) | (m_s1 & m_k1))}, "R9");
        cur = {runst, c2, lop, ais};
        n0 = (rd && addr == 3'd0) ? 8'h00 : m_s0;
        n1 = (rd && addr == 3'd1) ? 8'h00 : m_s1;
        n0 |= {b3, pnew, punk, pdec, pinc, pndf, cur[1] ^ m_prev[1], cur[0] ^ m_prev[0]};
        n1 |= {5'b0, cur[2] ^ m_prev[2], cur[3] ^ m_prev[3], rnew};
        @(posedge clk);
        m_s0 = n0; m_s1 = n1; m_prev = cur;
        if (wr && addr == 3'd2) m_k0 = wdata;
        if (wr && addr == 3'd3) m_k1 = wdata;
        if (rnew) m_rdi = rcode;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_read(input logic [2:0] a, input string tag);
        addr = a; rd = 1; tick(tag);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr = 1; wdata = d; tick("");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rcode = 0; lop = 0; ais = 0; c2 = 0; runst = 0;
        m_s0 = 0; m_s1 = 0; m_k0 = 0; m_k1 = 0; m_rdi = 0; m_prev = 0;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset values
        for (int a = 0; a < 8; a++) do_read(3'(a), "R1");

        // R3: pulse held until read
        b3 = 1; tick("");
        repeat (3) tick("");
        do_read(3'd0, "R3");
        check(rdata, 8'h00, "R3");

        // R6: event on the read-clear cycle survives
        pinc = 1; addr = 3'd0; rd = 1; tick("R6");
        do_read(3'd0, "R6");

        // R4: both directions, steady level sets nothing
        lop = 1; tick("");
        do_read(3'd0, "R4");
        tick("");
        do_read(3'd0, "R4");
        lop = 0; tick("");
        do_read(3'd0, "R4");
        c2 = 1; runst = 1; tick("");
        do_read(3'd1, "R4");
        c2 = 0; tick("");
        do_read(3'd1, "R4");
        runst = 0; tick("");

        // R8: code capture
        rnew = 1; rcode = 3'b101; tick("");
        do_read(3'd5, "R8");

        // R11: reading byte 1 keeps byte 0
        b3 = 1; tick("");
        do_read(3'd1, "R11");
        do_read(3'd0, "R11");

        // R9: latch while masked, then unmask
        pdec = 1; tick("");
        do_write(3'd2, 8'h10);
        do_read(3'd0, "R9");
        tick("");
        do_write(3'd2, 8'h00);

        // R10: writes to status/level/code addresses ignored
        b3 = 1; tick("");
        do_write(3'd0, 8'hFF);
        do_write(3'd1, 8'hFF);
        do_write(3'd4, 8'hFF);
        do_write(3'd5, 8'hFF);
        do_read(3'd0, "R10");
        do_read(3'd1, "R10");
        do_read(3'd5, "R10");
        do_write(3'd3, 8'hA5);
        do_read(3'd3, "R10");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int act;
            b3 = ($urandom % 6) == 0; pnew = ($urandom % 6) == 0;
            punk = ($urandom % 6) == 0; pdec = ($urandom % 6) == 0;
            pinc = ($urandom % 6) == 0; pndf = ($urandom % 6) == 0;
            rnew = ($urandom % 8) == 0; rcode = 3'($urandom);
            if (($urandom % 16) == 0) lop = ~lop;
            if (($urandom % 16) == 0) ais = ~ais;
            if (($urandom % 16) == 0) c2 = ~c2;
            if (($urandom % 16) == 0) runst = ~runst;
            act = $urandom % 8;
            if (act < 3) begin
                addr = 3'($urandom); rd = 1;
            end else if (act == 3) begin
                addr = 3'($urandom % 6); wr = 1; wdata = 8'($urandom);
            end
            tick("");
        end

        // R5: final drain reads
        lop = 0; ais = 0; c2 = 0; runst = 0; tick("");
        do_read(3'd0, "R5");
        do_read(3'd1, "R5");
        do_read(3'd0, "R5");
        do_read(3'd1, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule